// File: doc/BRIEF.md
# Space Register Selection Unit

The block stores the eight space identifiers that qualify a 64-bit offset into a global virtual address. Each memory-referencing access shows it the space selector carried in its instruction word, says whether that selector is two or three bits wide, and supplies the base register value. The block resolves those three inputs to one space register and returns that register's index and its 32-bit contents in the same cycle.

A three-bit selector names its register directly. A two-bit selector names registers one to three directly. A two-bit selector of zero never reaches register zero. It reaches one of the upper quadrant registers (four to seven), and the base register's two top bits choose which one. The same selector value of zero therefore resolves differently under the two widths. Software loads the registers through a single write port. Writes to the three highest registers need privileged mode. A write attempted without it is dropped and reported by a one-cycle fault pulse.

Top module: `space_sel_unit`

## Requirements
- R1: A synchronous active-high reset clears all eight space registers to zero and drives `priv_fault` low.
- R2: With `lk_short` = 0, `lk_idx` equals `lk_sfield` for all eight values and `lk_implicit` is 0.
- R3: With `lk_short` = 1 and `lk_sfield[1:0]` nonzero, `lk_idx` equals `{1'b0, lk_sfield[1:0]}`, `lk_implicit` is 0, and `lk_sfield[2]` has no effect.
- R4: With `lk_short` = 1 and `lk_sfield[1:0]` = 0, `lk_idx` equals 4 + `lk_base[63:62]` (so never 0), `lk_implicit` is 1, and `lk_sfield[2]` and `lk_base[61:0]` have no effect.
- R5: `lk_space` is, combinationally, the current contents of the register that `lk_idx` names.
- R6: With `wr_en` high and the write permitted, register `wr_idx` takes `wr_data` at the rising edge. A lookup of that register in the same cycle returns the old value, and the new value appears from the next cycle.
- R7: A write to index 5, 6 or 7 while `priv_mode` is low leaves every register unchanged. `priv_fault` is high in the cycle after that edge.
- R8: Writes to indices 0 to 4 take effect whatever the level of `priv_mode`, and they raise no fault. Writes to 5 to 7 take effect when `priv_mode` is high.
- R9: `priv_fault` is low in any cycle not directly preceded by a blocked write, so one blocked write gives a pulse exactly one cycle wide.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write request |
| wr_idx | input | 3 | Register index to write |
| wr_data | input | 32 | Space identifier to store |
| priv_mode | input | 1 | High when the requester is privileged |
| lk_sfield | input | 3 | Space selector from the instruction |
| lk_short | input | 1 | 1: selector is two bits wide (bit 2 ignored); 0: three bits |
| lk_base | input | 64 | Base register value |
| lk_idx | output | 3 | Index of the chosen space register |
| lk_space | output | 32 | Contents of the chosen register |
| lk_implicit | output | 1 | High when the base register picked the register |
| priv_fault | output | 1 | One-cycle pulse after a blocked privileged write |

## Verification
On every cycle the assertions check the selection rules for both selector widths against the port values. They also check that an uncommitted cycle leaves the register array untouched, that a committed write lands on its index, and that every fault pulse has a blocked write one cycle earlier. Only the bench scenarios can show that each stored value comes back through the lookup path, that a lookup in the same cycle as a write returns the old value, and that reset clears the contents. The bench also shows that blocked writes leave the upper registers as they were, which it reads back through ordinary lookups.

// File: rtl/space_sel_pkg.sv
package space_sel_pkg;

    localparam int NUM_SR     = 8;
    localparam int SR_IDX_W   = $clog2(NUM_SR);
    localparam int SPACE_W    = 32;
    localparam int BASE_W     = 64;
    localparam int SHORT_W    = 2;
    localparam int IMPL_BASE  = NUM_SR - (1 << SHORT_W);
    localparam int PRIV_FLOOR = 5;

    typedef logic [SR_IDX_W-1:0] sr_idx_t;
    typedef logic [SPACE_W-1:0]  space_id_t;

    typedef enum logic {
        FMT_WIDE  = 1'b0,
        FMT_SHORT = 1'b1
    } sfmt_e;

    typedef struct packed {
        sfmt_e               fmt;
        sr_idx_t             sfield;
        logic [SHORT_W-1:0]  base_top;
    } lookup_req_t;

    typedef struct packed {
        sr_idx_t idx;
        logic    implicit;
    } pick_t;

    typedef struct packed {
        logic      en;
        sr_idx_t   idx;
        space_id_t data;
    } wr_req_t;

    function automatic logic needs_priv(sr_idx_t i);
        return int'(i) >= PRIV_FLOOR;
    endfunction

endpackage

// File: rtl/space_sel_resolver.sv
module space_sel_resolver
    import space_sel_pkg::*;
(
    input  lookup_req_t req,
    output pick_t       pick
);

    logic [SHORT_W-1:0] short_sel;
    assign short_sel = req.sfield[SHORT_W-1:0];

    always_comb begin
        pick.idx      = req.sfield;
        pick.implicit = 1'b0;
        if (req.fmt == FMT_SHORT) begin
            if (short_sel == '0) begin
                pick.idx      = sr_idx_t'(IMPL_BASE) + sr_idx_t'(req.base_top);
                pick.implicit = 1'b1;
            end else begin
                pick.idx      = sr_idx_t'(short_sel);
            end
        end
    end

endmodule

// File: rtl/space_sel_wgate.sv
module space_sel_wgate
    import space_sel_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  wr_req_t req,
    input  logic    priv,
    output logic    commit,
    output logic    fault
);

    logic blocked;

    always_comb begin
        blocked = req.en && needs_priv(req.idx) && !priv;
        commit  = req.en && !blocked;
    end

    always_ff @(posedge clk) begin
        if (rst) fault <= 1'b0;
        else     fault <= blocked;
    end

    AST_BLOCK_PULSE: assert property (@(posedge clk) disable iff (rst)
        blocked |=> fault);  // R7
    AST_FAULT_HAS_CAUSE: assert property (@(posedge clk) disable iff (rst)
        fault |-> $past(blocked));  // R9
    AST_LOW_OPEN: assert property (@(posedge clk) disable iff (rst)
        (req.en && int'(req.idx) < PRIV_FLOOR) |-> commit);  // R8
    AST_PRIV_OPEN: assert property (@(posedge clk) disable iff (rst)
        (req.en && priv) |-> commit);  // R8

endmodule

// File: rtl/space_sel_regfile.sv
module space_sel_regfile
    import space_sel_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      commit,
    input  wr_req_t   req,
    input  sr_idx_t   rd_idx,
    output space_id_t rd_data
);

    logic [NUM_SR-1:0][SPACE_W-1:0] regs;

    always_ff @(posedge clk) begin
        if (rst) begin
            regs <= '0;
        end else if (commit) begin
            regs[req.idx] <= req.data;
        end
    end

    assign rd_data = regs[rd_idx];

    AST_HOLD_NO_COMMIT: assert property (@(posedge clk) disable iff (rst)
        !commit |=> regs == $past(regs));  // R7
    AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (rst)
        commit |=> regs[$past(req.idx)] == $past(req.data));  // R6

endmodule

// File: rtl/space_sel_unit.sv
module space_sel_unit
    import space_sel_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en,
    input  logic [SR_IDX_W-1:0] wr_idx,
    input  logic [SPACE_W-1:0] wr_data,
    input  logic               priv_mode,
    input  logic [SR_IDX_W-1:0] lk_sfield,
    input  logic               lk_short,
    input  logic [BASE_W-1:0]  lk_base,
    output logic [SR_IDX_W-1:0] lk_idx,
    output logic [SPACE_W-1:0] lk_space,
    output logic               lk_implicit,
    output logic               priv_fault
);

    lookup_req_t lk_req;
    pick_t       lk_pick;
    wr_req_t     wr_req;
    logic        wr_commit;
    logic        unused_base_low;

    assign lk_req.fmt      = lk_short ? FMT_SHORT : FMT_WIDE;
    assign lk_req.sfield   = lk_sfield;
    assign lk_req.base_top = lk_base[BASE_W-1 -: SHORT_W];
    assign unused_base_low = ^lk_base[BASE_W-SHORT_W-1:0];

    assign wr_req.en   = wr_en;
    assign wr_req.idx  = wr_idx;
    assign wr_req.data = wr_data;

    space_sel_resolver u_resolver (
        .req  (lk_req),
        .pick (lk_pick)
    );

    space_sel_wgate u_wgate (
        .clk    (clk),
        .rst    (rst),
        .req    (wr_req),
        .priv   (priv_mode),
        .commit (wr_commit),
        .fault  (priv_fault)
    );

    space_sel_regfile u_regfile (
        .clk     (clk),
        .rst     (rst),
        .commit  (wr_commit),
        .req     (wr_req),
        .rd_idx  (lk_pick.idx),
        .rd_data (lk_space)
    );

    assign lk_idx      = lk_pick.idx;
    assign lk_implicit = lk_pick.implicit;

    AST_WIDE_DIRECT: assert property (@(posedge clk) disable iff (rst)
        !lk_short |-> (lk_idx == lk_sfield) && !lk_implicit);  // R2
    AST_SHORT_EXPLICIT: assert property (@(posedge clk) disable iff (rst)
        (lk_short && lk_sfield[1:0] != 2'd0) |->
            (lk_idx == {1'b0, lk_sfield[1:0]}) && !lk_implicit);  // R3
    AST_SHORT_IMPLICIT: assert property (@(posedge clk) disable iff (rst)
        (lk_short && lk_sfield[1:0] == 2'd0) |->
            lk_idx[2] && (lk_idx[1:0] == lk_base[63:62]) && lk_implicit);  // R4
    AST_NEVER_ZERO_IMPLICIT: assert property (@(posedge clk) disable iff (rst)
        lk_implicit |-> lk_idx != '0);  // R4

endmodule

// File: tb/space_sel_unit_bench.sv
module space_sel_unit_bench;

    logic        clk = 1'b0;
    logic        rst;
    logic        wr_en;
    logic [2:0]  wr_idx;
    logic [31:0] wr_data;
    logic        priv_mode;
    logic [2:0]  lk_sfield;
    logic        lk_short;
    logic [63:0] lk_base;
    logic [2:0]  lk_idx;
    logic [31:0] lk_space;
    logic        lk_implicit;
    logic        priv_fault;

    int checks = 0;
    int fails  = 0;
    logic [31:0] model [8];

    always #2 clk = ~clk;

    space_sel_unit u_space_sel_unit (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .priv_mode(priv_mode), .lk_sfield(lk_sfield), .lk_short(lk_short),
        .lk_base(lk_base), .lk_idx(lk_idx), .lk_space(lk_space),
        .lk_implicit(lk_implicit), .priv_fault(priv_fault)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [2:0] exp_idx(input logic sh, input logic [2:0] s, input logic [1:0] top);
        if (!sh) return s;
        if (s[1:0] != 2'd0) return {1'b0, s[1:0]};
        return 3'd4 + {1'b0, top};
    endfunction

    task automatic look(input logic sh, input logic [2:0] s, input logic [63:0] b, input string req);
        logic [2:0] ei;
        logic       eimp;
        @(negedge clk);
        lk_short = sh; lk_sfield = s; lk_base = b;
        #1;
        ei   = exp_idx(sh, s, b[63:62]);
        eimp = sh && (s[1:0] == 2'd0);
        chk(lk_idx == ei, req, 64'(lk_idx), 64'(ei));
        chk(lk_implicit == eimp, req, 64'(lk_implicit), 64'(eimp));
        chk(lk_space == model[ei], {req, "/R5"}, 64'(lk_space), 64'(model[ei]));
    endtask

    task automatic wr(input logic [2:0] i, input logic [31:0] d, input logic p);
        bit blk;
        @(negedge clk);
        wr_en = 1'b1; wr_idx = i; wr_data = d; priv_mode = p;
        blk = (i >= 3'd5) && !p;
        @(negedge clk);
        wr_en = 1'b0;
        if (!blk) model[i] = d;
        #1;
        chk(priv_fault == blk, blk ? "R7 fault pulse" : "R8 no fault", 64'(priv_fault), 64'(blk));
        @(negedge clk);
        #1;
        chk(priv_fault == 1'b0, "R9 pulse width", 64'(priv_fault), 64'd0);
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        #(4 * 200000);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        rst = 1'b1; wr_en = 1'b0; wr_idx = '0; wr_data = '0; priv_mode = 1'b0;
        lk_sfield = '0; lk_short = 1'b0; lk_base = '0;
        for (int i = 0; i < 8; i++) model[i] = 32'h0;
        repeat (3) @(negedge clk);
        #1;
        chk(priv_fault == 1'b0, "R1 fault at reset", 64'(priv_fault), 64'd0);
        rst = 1'b0;
        // R1: every register reads zero after reset
        for (int i = 0; i < 8; i++) look(1'b0, 3'(i), 64'h0, "R1 reset value");

        // fill with privilege, distinct values
        for (int i = 0; i < 8; i++) wr(3'(i), 32'h5A00_0000 + 32'(i) * 32'h0011_0101 + 32'd7, 1'b1);

        // R2: wide selector sweep
        for (int i = 0; i < 8; i++) look(1'b0, 3'(i), {2'(i), 62'h1234_5678_9ABC}, "R2 wide");

        // R3/R4: short selector sweep over all selectors and base tops
        for (int s = 0; s < 8; s++)
            for (int t = 0; t < 4; t++)
                look(1'b1, 3'(s), {2'(t), 62'(s * 977 + t * 13)},
                     ((s % 4) == 0) ? "R4 short implicit" : "R3 short explicit");

        // R6: same-cycle write and lookup of one register
        for (int i = 0; i < 8; i++) begin
            logic [31:0] oldv;
            logic [31:0] newv;
            oldv = model[i];
            newv = ~oldv ^ 32'(i);
            @(negedge clk);
            lk_short = 1'b0; lk_sfield = 3'(i);
            wr_en = 1'b1; wr_idx = 3'(i); wr_data = newv; priv_mode = 1'b1;
            #1;
            chk(lk_space == oldv, "R6 old value same cycle", 64'(lk_space), 64'(oldv));
            @(negedge clk);
            wr_en = 1'b0;
            model[i] = newv;
            #1;
            chk(lk_space == newv, "R6 new value next cycle", 64'(lk_space), 64'(newv));
        end

        // R7/R8: unprivileged writes to every index
        for (int i = 0; i < 8; i++) begin
            wr(3'(i), 32'hC0DE_0000 | 32'(i), 1'b0);
            for (int j = 0; j < 8; j++) look(1'b0, 3'(j), 64'h0, (i >= 5) ? "R7 blocked hold" : "R8 open write");
        end

        // R8: privileged writes reach upper registers
        for (int i = 5; i < 8; i++) begin
            wr(3'(i), 32'hFACE_0000 | 32'(i), 1'b1);
            look(1'b1, 3'd0, {2'(i - 4), 62'h0}, "R8 privileged upper");
        end

        // R9: back-to-back blocked writes keep fault high, then it drops
        @(negedge clk);
        wr_en = 1'b1; wr_idx = 3'd6; wr_data = 32'h1; priv_mode = 1'b0;
        @(negedge clk);
        wr_idx = 3'd7;
        #1;
        chk(priv_fault == 1'b1, "R7 first blocked", 64'(priv_fault), 64'd1);
        @(negedge clk);
        wr_en = 1'b0;
        #1;
        chk(priv_fault == 1'b1, "R7 second blocked", 64'(priv_fault), 64'd1);
        @(negedge clk);
        #1;
        chk(priv_fault == 1'b0, "R9 drop after burst", 64'(priv_fault), 64'd0);
        look(1'b0, 3'd6, 64'h0, "R7 burst hold 6");
        look(1'b0, 3'd7, 64'h0, "R7 burst hold 7");

        // R1: reset again clears contents
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        for (int i = 0; i < 8; i++) model[i] = 32'h0;
        for (int i = 0; i < 8; i++) look(1'b0, 3'(i), 64'h0, "R1 second reset");

        summary();
    end

endmodule